// File: doc/BRIEF.md
# Per-Channel Logic Trigger Matcher

This block watches a bus of sampled logic channels and decides when a capture should trigger. Three control words supply one bit per channel. The enable word selects the channels that take part in the decision. The mode word chooses level or edge detection for each channel. The polarity word chooses high or low in level mode, and rising or falling in edge mode. A sample counts only in a cycle where its valid strobe is high.

An arm pulse starts a search. The block then raises a trigger on the first valid sample where every enabled channel meets its condition. When that happens it sets a sticky flag and gives a one-cycle pulse. Any later matches are ignored until the next arm. Edge detection compares each channel with its value on the previous valid sample. Arming clears that stored sample, so an edge needs two valid samples after the arm.

Top module: `trig_matcher`

## Requirements
- R1: After reset, `hit_o` and `hit_pulse_o` are 0. No valid sample can set them before the first arm pulse.
- R2: When mode bit n is 0, channel n is in level mode. It is met when the sample bit equals polarity bit n: 1 means high, 0 means low.
- R3: When mode bit n is 1, channel n is in edge mode. With polarity bit n at 1 it is met when the bit goes from 0 on the previous valid sample to 1 on the current one (rising). With polarity bit n at 0 it is met when the bit goes from 1 to 0 (falling).
- R4: A channel whose enable bit is 0 has no effect on the decision. If the enable word is all zeros, the first valid sample after arming triggers.
- R5: A trigger needs every enabled channel to meet its condition on the same valid sample (AND across channels).
- R6: The first valid sample after an arm never meets an edge condition.
- R7: A cycle with `smp_vld_i` at 0 is not evaluated. Its sample is not stored as the previous sample.
- R8: On a triggering sample, `hit_o` and `hit_pulse_o` go to 1 in the cycle after the sample is accepted. `hit_pulse_o` lasts exactly one cycle. `hit_o` stays at 1 until the next arm.
- R9: An arm pulse clears `hit_o` and the stored previous sample. A valid sample in the same cycle as an arm is discarded.
- R10: After a trigger, later matching samples produce no further pulse until the block is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | NUM_CH | Sample word; channel n is on bit n |
| smp_vld_i | input | 1 | High when `smp_i` holds a sample to evaluate |
| arm_i | input | 1 | Starts a new search; clears the flag and the stored sample |
| pol_i | input | NUM_CH | Per-channel polarity: high or rising (1), low or falling (0) |
| mode_i | input | NUM_CH | Per-channel mode: level (0) or edge (1) |
| ena_i | input | NUM_CH | Per-channel enable; 1 includes the channel |
| hit_o | output | 1 | Sticky triggered flag |
| hit_pulse_o | output | 1 | One-cycle pulse when the trigger fires |

## Verification
The assertions check the flag and pulse protocol on every cycle. The pulse lasts one cycle and appears only as the flag rises. The flag holds until an arm and is cleared by it. A rise of the flag always follows an accepted sample. The per-channel conditions themselves are shown only by the bench scenarios: level and edge polarity, masking, the AND across channels, the missing edge on the first sample after an arm, and the skipping of invalid cycles. Each scenario drives a sample sequence whose outcome is known in advance.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SEEK = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/trig_chan_cond.sv
module trig_chan_cond (
  input  logic cur_i,
  input  logic prev_i,
  input  logic prev_vld_i,
  input  logic pol_i,
  input  logic mode_i,
  input  logic ena_i,
  output logic ok_o
);
  logic lvl_ok, edge_ok;

  assign lvl_ok  = (cur_i == pol_i);
  // polarity 1: rising, 0: falling; needs a stored sample
  assign edge_ok = prev_vld_i && (cur_i == pol_i) && (prev_i != pol_i);
  assign ok_o    = !ena_i || (mode_i ? edge_ok : lvl_ok);
endmodule

// File: rtl/trig_hist.sv
module trig_hist #(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [NUM_CH-1:0] smp_i,
  output logic [NUM_CH-1:0] prev_o,
  output logic              prev_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o     <= '0;
      prev_vld_o <= 1'b0;
    end else if (clr_i) begin
      prev_o     <= '0;
      prev_vld_o <= 1'b0;
    end else if (take_i) begin
      prev_o     <= smp_i;
      prev_vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic take_i,
  input  logic all_ok_i,
  output logic hit_o,
  output logic hit_pulse_o
);
  seq_state_e state_q, state_d;
  logic       fire;

  assign fire = (state_q == SEQ_SEEK) && take_i && all_ok_i;

  always_comb begin
    state_d = state_q;
    if (arm_i)     state_d = SEQ_SEEK;
    else if (fire) state_d = SEQ_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      hit_pulse_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      hit_pulse_o <= fire;
    end
  end

  assign hit_o = (state_q == SEQ_DONE);
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher #(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] smp_i,
  input  logic              smp_vld_i,
  input  logic              arm_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  logic [NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0] ena_i,
  output logic              hit_o,
  output logic              hit_pulse_o
);
  logic              take;
  logic [NUM_CH-1:0] prev_q;
  logic              prev_vld_q;
  logic [NUM_CH-1:0] ch_ok;

  // arm wins over a same-cycle sample
  assign take = smp_vld_i && !arm_i;

  trig_hist #(.NUM_CH(NUM_CH)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (arm_i),
    .take_i     (take),
    .smp_i      (smp_i),
    .prev_o     (prev_q),
    .prev_vld_o (prev_vld_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trig_chan_cond u_cond (
      .cur_i      (smp_i[c]),
      .prev_i     (prev_q[c]),
      .prev_vld_i (prev_vld_q),
      .pol_i      (pol_i[c]),
      .mode_i     (mode_i[c]),
      .ena_i      (ena_i[c]),
      .ok_o       (ch_ok[c])
    );
  end

  trig_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .take_i      (take),
    .all_ok_i    (&ch_ok),
    .hit_o       (hit_o),
    .hit_pulse_o (hit_pulse_o)
  );
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_vld_i,
  input logic arm_i,
  input logic hit_o,
  input logic hit_pulse_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_pulse_o |=> !hit_pulse_o); // R8

  AST_PULSE_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_pulse_o |-> (hit_o && !$past(hit_o))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !arm_i) |=> hit_o); // R8

  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!hit_o && !hit_pulse_o)); // R9

  AST_RISE_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> ($past(smp_vld_i) && !$past(arm_i))); // R7

  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !arm_i) |=> !hit_pulse_o); // R10
endmodule

bind trig_matcher trig_matcher_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_vld_i   (smp_vld_i),
  .arm_i       (arm_i),
  .hit_o       (hit_o),
  .hit_pulse_o (hit_pulse_o)
);

// File: tb/trig_matcher_tb.sv
module trig_matcher_tb;
  localparam int NUM_CH = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] smp_i = '0;
  logic              smp_vld_i = 1'b0;
  logic              arm_i = 1'b0;
  logic [NUM_CH-1:0] pol_i = '0;
  logic [NUM_CH-1:0] mode_i = '0;
  logic [NUM_CH-1:0] ena_i = '0;
  logic              hit_o, hit_pulse_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  trig_matcher #(.NUM_CH(NUM_CH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .arm_i(arm_i), .pol_i(pol_i), .mode_i(mode_i), .ena_i(ena_i),
    .hit_o(hit_o), .hit_pulse_o(hit_pulse_o)
  );

  task automatic chk(input string tag, input logic exp_hit, input logic exp_pls);
    n_chk++;
    if (hit_o !== exp_hit || hit_pulse_o !== exp_pls) begin
      n_bad++;
      $display("FAIL %s: hit/pulse actual %b%b expected %b%b", tag, hit_o, hit_pulse_o,
               exp_hit, exp_pls);
    end
  endtask

  task automatic cfg(input logic [NUM_CH-1:0] e, m, p);
    ena_i = e; mode_i = m; pol_i = p;
  endtask

  task automatic arm();
    @(negedge clk_i); arm_i = 1'b1;
    @(negedge clk_i); arm_i = 1'b0;
  endtask

  task automatic smp(input logic [NUM_CH-1:0] v);
    @(negedge clk_i); smp_i = v; smp_vld_i = 1'b1;
    @(negedge clk_i); smp_vld_i = 1'b0;
  endtask

  task automatic idle_smp(input logic [NUM_CH-1:0] v);
    @(negedge clk_i); smp_i = v; smp_vld_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 reset state", 1'b0, 1'b0);
    cfg('0, '0, '0);
    smp(32'h1);
    chk("R1 no trigger before arm", 1'b0, 1'b0);
  endtask

  task automatic t_level();
    cfg(32'h3, 32'h0, 32'h1);  // ch0 high, ch1 low
    arm();
    smp(32'h3);
    chk("R5 ch1 not low", 1'b0, 1'b0);
    smp(32'h0);
    chk("R2 ch0 not high", 1'b0, 1'b0);
    idle_smp(32'h1);
    chk("R7 invalid cycle ignored", 1'b0, 1'b0);
    smp(32'h8000_0001);
    chk("R2 level match, R4 masked bit31", 1'b1, 1'b1);
    @(negedge clk_i);
    chk("R8 pulse one cycle, flag sticky", 1'b1, 1'b0);
    smp(32'h1);
    chk("R10 no second pulse", 1'b1, 1'b0);
    arm();
    chk("R9 arm clears flag", 1'b0, 1'b0);
  endtask

  task automatic t_edge();
    cfg(32'h1, 32'h1, 32'h1);  // ch0 rising
    arm();
    smp(32'h1);
    chk("R6 first sample no edge", 1'b0, 1'b0);
    smp(32'h0);
    chk("R3 falling is not rising", 1'b0, 1'b0);
    smp(32'h1);
    chk("R3 rising edge fires", 1'b1, 1'b1);
    cfg(32'h1, 32'h1, 32'h0);  // ch0 falling; prev sample was 1
    arm();
    smp(32'h0);
    chk("R9 stored sample cleared by arm", 1'b0, 1'b0);
    smp(32'h1);
    chk("R3 rising is not falling", 1'b0, 1'b0);
    smp(32'h0);
    chk("R3 falling edge fires", 1'b1, 1'b1);
    cfg(32'h1, 32'h1, 32'h1);
    arm();
    smp(32'h0);
    idle_smp(32'h1);
    smp(32'h1);
    chk("R7 invalid sample not stored as previous", 1'b1, 1'b1);
  endtask

  task automatic t_mixed();
    cfg(32'h3, 32'h2, 32'h3);  // ch0 high level, ch1 rising
    arm();
    smp(32'h0);
    smp(32'h2);
    chk("R5 edge met but level not", 1'b0, 1'b0);
    smp(32'h1);
    chk("R5 level met but edge not", 1'b0, 1'b0);
    smp(32'h3);
    chk("R5 both met", 1'b1, 1'b1);
  endtask

  task automatic t_mask0();
    cfg('0, 32'hFFFF_FFFF, 32'h0);
    arm();
    chk("R9 flag clear after arm", 1'b0, 1'b0);
    smp(32'h1234_5678);
    chk("R4 empty mask fires on first sample", 1'b1, 1'b1);
  endtask

  task automatic t_collide();
    cfg('0, '0, '0);
    @(negedge clk_i); arm_i = 1'b1; smp_vld_i = 1'b1; smp_i = 32'h5;
    @(negedge clk_i); arm_i = 1'b0; smp_vld_i = 1'b0;
    chk("R9 same-cycle sample discarded", 1'b0, 1'b0);
    smp(32'h5);
    chk("R9 next sample fires", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_level();
    t_edge();
    t_mixed();
    t_mask0();
    t_collide();
    repeat (2) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule